// File: doc/BRIEF.md
# Centre-Aligned Seven-Segment Space-Vector Pulse Sequencer

This block drives the three upper-switch gates of a two-level three-phase bridge. Each switching period it plays a symmetric pattern built from one period descriptor: the dwell ticks of the first active vector, of the second active vector and of the zero vectors. The descriptor also carries the two active switch codes and the period length in ticks. The zero time is shared evenly between the all-low and the all-high vector. The active halves sit mirrored on both sides of a central all-high segment. As a result every gate bit rises once in the first half and falls once in the second half, like a triangular carrier compared with three thresholds.

Descriptors arrive over a valid/ready stream with a single waiting slot. A descriptor is accepted on any clock where `in_valid` and `in_ready` are both high. The upstream side must keep the descriptor stable while `in_valid` is high and `in_ready` is low. `in_ready` stays low while a descriptor waits for the next period boundary. At each boundary the sequencer adopts the waiting descriptor. If no descriptor is waiting, it repeats the previous one. A one-cycle `per_start` pulse and a segment index make the pattern observable.

Top module: `svm_pulse_seq`

## Requirements
- R1: A descriptor is accepted when `in_valid` and `in_ready` are high at a rising edge. Only one descriptor may wait, and `in_ready` is low from the cycle after acceptance until the waiting descriptor is adopted.
- R2: A waiting descriptor is adopted only at a period boundary. The period in progress keeps its lengths and codes.
- R3: If no descriptor is waiting at a boundary, the last adopted descriptor is played again unchanged.
- R4: Segment indices 0 to 6 play in ascending order within a period. The dwell lengths are fixed as follows:
  - Segments 0 and 6 are all-low and last floor(tz/4) ticks each.
  - Segments 1 and 5 carry code `in_vi` and last floor(ti/2) ticks each.
  - Segments 2 and 4 carry code `in_vj` and last floor(tj/2) ticks each.
  - Segment 3 is all-high.
- R5: The central segment lasts `in_per` minus twice the sum of the three halves, or 0 if that is negative. This gives it every odd remainder and all slack, so a period lasts exactly `in_per` ticks whenever `in_per` >= ti+tj+tz.
- R6: A zero-length segment is skipped: its index never appears and its code is never driven. A descriptor whose every segment would be empty yields a one-tick all-low period.
- R7: Within a period, gate bits only rise while the index is 0 to 3 and only fall while it is 4 to 6. When all seven segments are non-empty, there are exactly six gate changes per period and each flips one bit.
- R8: `gate_uvw` bit 2 is phase U, bit 1 is V and bit 0 is W, and a 1 means the upper switch is on. `in_vi` and `in_vj` use the same bit order.
- R9: A code pair is valid when `in_vi` has one bit set, `in_vj` has two bits set, and `in_vi` is contained in `in_vj`. A descriptor with any other pair keeps its period timing but drives all gates low for the whole period.
- R10: After reset the block is idle: gates low, index 0, `per_start` low, `in_ready` high. It stays idle until the first descriptor. `per_start` is high for exactly the first tick of every period.
- R11: Per period, each phase is high for 2·floor(ti/2)·vi[p] + 2·floor(tj/2)·vj[p] + centre ticks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Descriptor valid |
| in_ready | output | 1 | Waiting slot empty |
| in_ti | input | TW | First active dwell, ticks |
| in_tj | input | TW | Second active dwell, ticks |
| in_tz | input | TW | Zero-vector dwell, ticks |
| in_per | input | TW | Period length, ticks |
| in_vi | input | 3 | First active code (one bit set) |
| in_vj | input | 3 | Second active code (two bits set) |
| gate_uvw | output | 3 | Upper gate commands U,V,W |
| per_start | output | 1 | High on the first tick of a period |
| seg_idx | output | 3 | Index of the segment being played |

## Verification
Several properties are checked on every cycle:
- the index never leaves 0..6 and never runs backwards inside a period;
- gate bits only rise in the first half and only fall in the second;
- the slot closes after each acceptance;
- every adoption falls on a period start.

Dwell arithmetic cannot be expressed as a simple property and is left to the bench scenarios. The bench measures period lengths and per-phase high times against the formulas, and confirms that a descriptor arriving mid-period leaves the running period untouched. It also covers the repeat rule, the exact six single-bit changes, the skipping of empty segments and the zero-output treatment of bad code pairs.

// File: rtl/svm_seq_pkg.sv
package svm_seq_pkg;
  localparam int NSEG = 7;
  localparam int NPH  = 3;
  localparam int SEGW = $clog2(NSEG);

  typedef logic [NPH-1:0] sw_vec_t;

  localparam sw_vec_t VEC_LOW  = '0;
  localparam sw_vec_t VEC_HIGH = '1;

  // single-upper code contained in a double-upper code: one step apart
  function automatic logic pair_adjacent(input sw_vec_t a, input sw_vec_t b);
    return ($countones(a) == 1) && ($countones(b) == 2) && ((a & ~b) == '0);
  endfunction
endpackage

// File: rtl/svm_desc_slot.sv
module svm_desc_slot #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] out_data
);
  logic [W-1:0] hold_q;
  logic         full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      hold_q <= '0;
    end else if (in_valid && !full_q) begin
      full_q <= 1'b1;
      hold_q <= in_data;
    end else if (take) begin
      full_q <= 1'b0;
    end
  end

  assign in_ready = !full_q;
  assign full     = full_q;
  assign out_data = hold_q;
endmodule

// File: rtl/svm_seg_plan.sv
module svm_seg_plan
  import svm_seq_pkg::*;
#(
  parameter int TW = 12
) (
  input  logic    [TW-1:0]          ti,
  input  logic    [TW-1:0]          tj,
  input  logic    [TW-1:0]          tz,
  input  logic    [TW-1:0]          per,
  input  sw_vec_t                   vi,
  input  sw_vec_t                   vj,
  output logic    [NSEG-1:0][TW-1:0] seg_len,
  output sw_vec_t [NSEG-1:0]          seg_vec
);
  localparam int SW = TW + 2;

  logic [TW-1:0] q_len, hi_len, hj_len, mid_len;
  logic [SW-1:0] half_sum, used, per_ext;
  logic          codes_ok, empty;

  assign q_len    = {2'b00, tz[TW-1:2]};
  assign hi_len   = {1'b0, ti[TW-1:1]};
  assign hj_len   = {1'b0, tj[TW-1:1]};
  assign half_sum = {2'b00, q_len} + {2'b00, hi_len} + {2'b00, hj_len};
  assign used     = {half_sum[SW-2:0], 1'b0};
  assign per_ext  = {2'b00, per};
  assign mid_len  = (per_ext > used) ? TW'(per_ext - used) : '0;
  assign empty    = (half_sum == '0) && (per == '0);
  assign codes_ok = pair_adjacent(vi, vj);

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    localparam int RUNG = (s < NSEG/2) ? s : NSEG-1-s;
    if (RUNG == 0) begin : g_zero
      assign seg_len[s] = (s == 0 && empty) ? TW'(1) : q_len;
      assign seg_vec[s] = VEC_LOW;
    end else if (RUNG == 1) begin : g_first
      assign seg_len[s] = hi_len;
      assign seg_vec[s] = codes_ok ? vi : VEC_LOW;
    end else if (RUNG == 2) begin : g_second
      assign seg_len[s] = hj_len;
      assign seg_vec[s] = codes_ok ? vj : VEC_LOW;
    end else begin : g_centre
      assign seg_len[s] = mid_len;
      assign seg_vec[s] = codes_ok ? VEC_HIGH : VEC_LOW;
    end
  end
endmodule

// File: rtl/svm_seg_walker.sv
module svm_seg_walker
  import svm_seq_pkg::*;
#(
  parameter int TW = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pend,
  input  logic    [NSEG-1:0][TW-1:0] new_len,
  input  sw_vec_t [NSEG-1:0]          new_vec,
  output logic                       take,
  output sw_vec_t                    gate,
  output logic                       per_start,
  output logic    [SEGW-1:0]         seg_idx
);
  logic    [NSEG-1:0][TW-1:0] act_len, len_n;
  sw_vec_t [NSEG-1:0]          act_vec, vec_n;
  logic    [SEGW-1:0]          seg_q, seg_n, nxt_idx, first_new, first_act;
  logic    [TW-1:0]            rem_q, rem_n;
  logic                        run_q, run_n, ps_q, ps_n, found;
  sw_vec_t                     gate_q, gate_n;

  // nearest non-empty segment after the current one
  always_comb begin
    found   = 1'b0;
    nxt_idx = seg_q;
    for (int j = NSEG-1; j >= 0; j--) begin
      if (j > int'(seg_q) && act_len[j] != '0) begin
        found   = 1'b1;
        nxt_idx = SEGW'(j);
      end
    end
  end

  // first non-empty segment of the incoming and of the held plan
  always_comb begin
    first_new = '0;
    first_act = '0;
    for (int j = NSEG-1; j >= 0; j--) begin
      if (new_len[j] != '0) first_new = SEGW'(j);
      if (act_len[j] != '0) first_act = SEGW'(j);
    end
  end

  always_comb begin
    run_n = run_q;
    seg_n = seg_q;
    rem_n = rem_q;
    len_n = act_len;
    vec_n = act_vec;
    ps_n  = 1'b0;
    take  = 1'b0;
    if (run_q && rem_q != '0) begin
      rem_n = rem_q - 1'b1;
    end else if (run_q && found) begin
      seg_n = nxt_idx;
      rem_n = act_len[nxt_idx] - 1'b1;
    end else if (run_q || pend) begin
      run_n = 1'b1;
      ps_n  = 1'b1;
      if (pend) begin
        take  = 1'b1;
        len_n = new_len;
        vec_n = new_vec;
        seg_n = first_new;
        rem_n = new_len[first_new] - 1'b1;
      end else begin
        seg_n = first_act;
        rem_n = act_len[first_act] - 1'b1;
      end
    end
    gate_n = run_n ? vec_n[seg_n] : VEC_LOW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      seg_q   <= '0;
      rem_q   <= '0;
      act_len <= '0;
      act_vec <= '0;
      ps_q    <= 1'b0;
      gate_q  <= VEC_LOW;
    end else begin
      run_q   <= run_n;
      seg_q   <= seg_n;
      rem_q   <= rem_n;
      act_len <= len_n;
      act_vec <= vec_n;
      ps_q    <= ps_n;
      gate_q  <= gate_n;
    end
  end

  assign gate      = gate_q;
  assign per_start = ps_q;
  assign seg_idx   = seg_q;
endmodule

// File: rtl/svm_pulse_seq.sv
module svm_pulse_seq
  import svm_seq_pkg::*;
#(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [TW-1:0] in_ti,
  input  logic [TW-1:0] in_tj,
  input  logic [TW-1:0] in_tz,
  input  logic [TW-1:0] in_per,
  input  logic [2:0]    in_vi,
  input  logic [2:0]    in_vj,
  output logic [2:0]    gate_uvw,
  output logic          per_start,
  output logic [2:0]    seg_idx
);
  localparam int DW = 4*TW + 2*NPH;

  logic [DW-1:0]              slot_data;
  logic                       pend_w, take_w;
  logic [TW-1:0]              h_ti, h_tj, h_tz, h_per;
  sw_vec_t                    h_vi, h_vj;
  logic    [NSEG-1:0][TW-1:0] plan_len;
  sw_vec_t [NSEG-1:0]          plan_vec;
  logic    [SEGW-1:0]          idx_w;

  svm_desc_slot #(.W(DW)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  ({in_ti, in_tj, in_tz, in_per, in_vi, in_vj}),
    .take     (take_w),
    .full     (pend_w),
    .out_data (slot_data)
  );

  assign {h_ti, h_tj, h_tz, h_per, h_vi, h_vj} = slot_data;

  svm_seg_plan #(.TW(TW)) u_plan (
    .ti      (h_ti),
    .tj      (h_tj),
    .tz      (h_tz),
    .per     (h_per),
    .vi      (h_vi),
    .vj      (h_vj),
    .seg_len (plan_len),
    .seg_vec (plan_vec)
  );

  svm_seg_walker #(.TW(TW)) u_walk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pend      (pend_w),
    .new_len   (plan_len),
    .new_vec   (plan_vec),
    .take      (take_w),
    .gate      (gate_uvw),
    .per_start (per_start),
    .seg_idx   (idx_w)
  );

  assign seg_idx = 3'(idx_w);
endmodule

// File: rtl/svm_pulse_seq_chk.sv
module svm_pulse_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [2:0] gate_uvw,
  input logic       per_start,
  input logic [2:0] seg_idx,
  input logic       take,
  input logic       pend
);
  assert_idx_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seg_idx <= 3'd6);

  assert_idx_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !per_start |-> (seg_idx >= $past(seg_idx)));

  assert_rise_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!per_start && seg_idx <= 3'd3) |-> (($past(gate_uvw) & ~gate_uvw) == 3'b000));

  assert_fall_half_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!per_start && seg_idx >= 3'd4) |-> ((gate_uvw & ~$past(gate_uvw)) == 3'b000));

  assert_slot_closes_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_take_needs_pend_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> pend);

  assert_take_at_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> per_start);
endmodule

bind svm_pulse_seq svm_pulse_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .gate_uvw  (gate_uvw),
  .per_start (per_start),
  .seg_idx   (seg_idx),
  .take      (take_w),
  .pend      (pend_w)
);

// File: tb/svm_pulse_seq_tb.sv
module svm_pulse_seq_tb;
  localparam int TW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [TW-1:0] in_ti = '0, in_tj = '0, in_tz = '0, in_per = '0;
  logic [2:0]    in_vi = '0, in_vj = '0;
  logic          in_ready, per_start;
  logic [2:0]    gate_uvw, seg_idx;

  always #4 clk = ~clk;

  svm_pulse_seq #(.TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ti(in_ti), .in_tj(in_tj), .in_tz(in_tz), .in_per(in_per),
    .in_vi(in_vi), .in_vj(in_vj), .gate_uvw(gate_uvw),
    .per_start(per_start), .seg_idx(seg_idx)
  );

  typedef struct {
    int ti; int tj; int tz; int per;
    logic [2:0] vi; logic [2:0] vj;
  } desc_t;

  int total = 0, bad = 0;
  int m_len, m_chg, m_multi, m_mask;
  int m_high [3];
  bit m_order;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit pair_ok(desc_t d);
    return ($countones(d.vi) == 1) && ($countones(d.vj) == 2) && ((d.vi & ~d.vj) == 3'b000);
  endfunction

  function automatic int mid_of(desc_t d);
    int used = 2*(d.tz/4 + d.ti/2 + d.tj/2);
    return (d.per > used) ? d.per - used : 0;
  endfunction

  function automatic int exp_len(desc_t d);
    int used = 2*(d.tz/4 + d.ti/2 + d.tj/2);
    int l = used + mid_of(d);
    return (l == 0) ? 1 : l;
  endfunction

  // bit 2 = U, bit 1 = V, bit 0 = W (R8)
  function automatic int exp_high(desc_t d, int p);
    if (!pair_ok(d)) return 0;
    return 2*(d.ti/2)*int'(d.vi[p]) + 2*(d.tj/2)*int'(d.vj[p]) + mid_of(d);
  endfunction

  function automatic desc_t mk(int ti, int tj, int tz, int per, logic [2:0] vi, logic [2:0] vj);
    desc_t d;
    d.ti = ti; d.tj = tj; d.tz = tz; d.per = per; d.vi = vi; d.vj = vj;
    return d;
  endfunction

  task automatic send(input desc_t d);
    bit rdy;
    in_ti = TW'(d.ti); in_tj = TW'(d.tj); in_tz = TW'(d.tz); in_per = TW'(d.per);
    in_vi = d.vi; in_vj = d.vj;
    in_valid = 1'b1;
    while (1) begin
      rdy = in_ready;
      @(negedge clk);
      if (rdy) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic measure();
    logic [2:0] pg, pi;
    while (!per_start) @(negedge clk);
    m_len = 0; m_chg = 0; m_multi = 0; m_mask = 0; m_order = 1'b1;
    for (int p = 0; p < 3; p++) m_high[p] = 0;
    while (1) begin
      for (int p = 0; p < 3; p++) if (gate_uvw[p]) m_high[p]++;
      m_mask |= (1 << seg_idx);
      m_len++;
      pg = gate_uvw; pi = seg_idx;
      @(negedge clk);
      if (per_start) break;
      if ((pg ^ gate_uvw) != 3'b000) m_chg++;
      if ($countones(pg ^ gate_uvw) > 1) m_multi++;
      if (seg_idx < pi) m_order = 1'b0;
    end
  endtask

  task automatic check_period(input desc_t d, input string tag, input bit strict);
    chk(m_len == exp_len(d), {tag, " R5 period length"}, m_len, exp_len(d));
    for (int p = 0; p < 3; p++)
      chk(m_high[p] == exp_high(d, p), {tag, " R11 R8 phase high time"}, m_high[p], exp_high(d, p));
    chk(m_order, {tag, " R4 index order"}, int'(m_order), 1);
    if (strict) begin
      chk(m_chg == 6, {tag, " R7 change count"}, m_chg, 6);
      chk(m_multi == 0, {tag, " R7 single-bit changes"}, m_multi, 0);
      chk(m_mask == 8'h7f, {tag, " R4 all segments seen"}, m_mask, 8'h7f);
    end
  endtask

  task automatic run_case(input desc_t d, input string tag, input bit strict);
    send(d);
    if (per_start) @(negedge clk);
    measure();
    check_period(d, tag, strict);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    desc_t a, b, d;
    int k, vi_i, vj_i, ti, tj, tz;
    void'($urandom(32'h5e9a17));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 idle after reset, R1 slot open
    chk(gate_uvw == 3'b000, "R10 reset gate", gate_uvw, 0);
    chk(per_start == 1'b0, "R10 reset per_start", per_start, 0);
    chk(seg_idx == 3'd0, "R10 reset index", seg_idx, 0);
    chk(in_ready == 1'b1, "R1 reset ready", in_ready, 1);
    repeat (6) @(negedge clk);
    chk(gate_uvw == 3'b000 && !per_start, "R10 stays idle", gate_uvw, 0);

    // R8: vi = U only, vj = U+V
    a = mk(40, 30, 40, 110, 3'b100, 3'b110);
    run_case(a, "A", 1'b1);

    // R3 repeat of A while B arrives mid-period (R2), then R1 back-pressure
    b = mk(21, 17, 23, 64, 3'b010, 3'b011);
    fork
      measure();
      begin
        repeat (4) @(negedge clk);
        send(b);
        chk(in_ready == 1'b0, "R1 ready low while waiting", in_ready, 0);
      end
    join
    check_period(a, "R2 R3 running period kept", 1'b1);
    measure();
    check_period(b, "R2 adopted at boundary", 1'b1);

    // R6: only the centre is non-empty
    d = mk(1, 0, 3, 4, 3'b001, 3'b101);
    run_case(d, "R6 centre only", 1'b0);
    chk(m_mask == 8'h08, "R6 skipped indices", m_mask, 8'h08);
    // R6: zero outer segments
    d = mk(10, 8, 2, 20, 3'b001, 3'b011);
    run_case(d, "R6 no outer zero", 1'b0);
    chk(m_mask == 8'h3e, "R6 skipped outer", m_mask, 8'h3e);
    chk(m_multi == 0, "R7 single-bit with skipped ends", m_multi, 0);
    // R6: all empty gives one all-low tick
    d = mk(0, 0, 0, 0, 3'b100, 3'b110);
    run_case(d, "R6 all empty", 1'b0);
    chk(m_mask == 8'h01, "R6 single lead tick", m_mask, 8'h01);
    // R9: bad code pair
    d = mk(30, 20, 16, 70, 3'b110, 3'b100);
    run_case(d, "R9 bad pair", 1'b0);
    // R5: odd values and slack go to centre
    d = mk(7, 9, 13, 33, 3'b001, 3'b101);
    run_case(d, "R5 odd split", 1'b1);

    for (int n = 0; n < 24; n++) begin
      k    = $urandom_range(0, 2);
      vi_i = 1 << k;
      vj_i = vi_i | (1 << ((k + 1 + $urandom_range(0, 1)) % 3));
      ti = $urandom_range(2, 120);
      tj = $urandom_range(2, 120);
      tz = $urandom_range(4, 120);
      d = mk(ti, tj, tz, ti + tj + tz + $urandom_range(0, 5), 3'(vi_i), 3'(vj_i));
      run_case(d, "random R4 R7 R11", 1'b1);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule